// File: doc/BRIEF.md
# Tamper Detection and Event Controller

This block guards a secure domain. It watches two active-low external tamper pins and thirteen single-line internal alarm sources. Typical internal sources are supply and temperature monitors, clock-loss detection, debug access, counter overflow and crypto faults. Two internal positions are reserved and can never fire. Each external pin gets a short pre-charge before every sample. It is sampled on a slow divided schedule and accepted only after a run of identical active samples.

Every source has its own enable and interrupt-enable bit. A detected event latches a sticky status flag, which software clears by writing ones to a clear register. In confirmed mode, a newly latched flag pulses an erase output that wipes the secret store. One interrupt line is raised while any latched flag is also interrupt-enabled. A fixed-priority reason code names the most important latched source.

Software reaches the block through a plain valid/address/data port. Writes take effect at the clock edge. Reads are combinational in the same cycle.

Top module: `tamper_ctrl`

## Requirements
- R1: After reset, the enable, interrupt-enable, status, configuration and reason registers all read 0, and irq_o and erase_o are 0.
- R2: Flag bit positions are fixed: bit 0 is external pin 1, bit 1 is external pin 2, and bit k+1 is internal source k (k = 1..13). Internal sources 4 and 10 (bits 5 and 11) read back 0 in the enable registers, even after a write of 1, and never latch.
- R3: An internal source that is high at a clock edge while its enable bit (address 0) is set latches its status bit (address 2) at that edge. A disabled source leaves the status unchanged.
- R4: Writing ones to the clear register (address 3) clears those status bits at the write edge. Clear beats a simultaneous set, so a source that is still active re-latches at the following edge.
- R5: pch_o is high for exactly PRE_CYC consecutive cycles, ending just before each sample cycle. Configuration bit 0 (address 4) set to 1 holds pch_o low.
- R6: The external pins are sampled once every SAMPLE_DIV cycles.
- R7: An external pin is active when low. Its flag latches at the sample on which FILT_N consecutive samples have been active. A sample that differs from the one before it restarts the count.
- R8: With configuration bit 1 at 0 (confirmed mode), erase_o is high for exactly the one cycle in which one or more status bits first appear set. With bit 1 at 1, erase_o stays low.
- R9: irq_o is high whenever some status bit and its interrupt-enable bit (address 1) are both set. It stays high until those bits are cleared.
- R10: reason_o, also readable at address 5, is 0 when no status bit is set. Otherwise it is the index plus one of the lowest set status bit, which gives the order ext1, ext2, internal 1, 2, 3, 5, 6, 7, 8, 9, 11, 12, 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Register access valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address |
| req_wdata | input | DW | Write data |
| rd_data | output | DW | Read data for the current address |
| ext_tamper_n | input | N_EXT | Active-low external tamper pins |
| int_tamper | input | N_INT | Active-high internal tamper lines |
| pch_o | output | 1 | Pin pre-charge drive |
| erase_o | output | 1 | Secret erase pulse |
| irq_o | output | 1 | Tamper interrupt |
| reason_o | output | clog2(N_EXT+N_INT+1) | Priority reason code |

## Verification
Internal-source flags, the erase pulse, the interrupt and the reason code are all due in the cycle after the edge that saw the source. The bench drives at falling edges and reads at the next falling edge. A clear is checked at the falling edge right after the write edge, and its re-latch one edge later. External flags are due at the edge that ends the FILT_N-th active sample cycle. The bench locks onto that schedule by watching pch_o fall, which marks the sample cycle, and checks once per sample period. Pre-charge length and sample period are counted in falling edges between pch_o transitions.

// File: rtl/tamp_pkg.sv
package tamp_pkg;
  localparam logic [2:0] A_ENA  = 3'd0;
  localparam logic [2:0] A_IEN  = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_CLR  = 3'd3;
  localparam logic [2:0] A_CFG  = 3'd4;
  localparam logic [2:0] A_RSN  = 3'd5;
  localparam int CFG_PCH_OFF = 0;
  localparam int CFG_NOERASE = 1;
  localparam int CFG_W       = 2;
endpackage

// File: rtl/tamp_tick.sv
module tamp_tick #(
  parameter int DIV = 256,
  parameter int PRE = 8
) (
  input  logic clk,
  input  logic rst_l,
  output logic strobe_o,
  output logic pch_win_o
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST   = CW'(DIV - 1);
  localparam logic [CW-1:0] PSTART = CW'(DIV - 1 - PRE);

  logic [CW-1:0] div_q, div_d;

  always_comb begin
    strobe_o  = (div_q == LAST);
    pch_win_o = (div_q >= PSTART) && (div_q != LAST);
    div_d     = strobe_o ? '0 : div_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tamp_filter.sv
module tamp_filter #(
  parameter int FILT_N = 4
) (
  input  logic clk,
  input  logic rst_l,
  input  logic strobe_i,
  input  logic pin_n_i,
  output logic hit_o
);
  localparam int CW = $clog2(FILT_N + 1);
  localparam logic [CW-1:0] CMAX = CW'(FILT_N);

  logic [1:0]    sync_q, sync_d;
  logic          prev_q, prev_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          smp;

  always_comb begin
    sync_d = {sync_q[0], ~pin_n_i};
    smp    = sync_q[1];
    prev_d = prev_q;
    cnt_d  = cnt_q;
    if (strobe_i) begin
      prev_d = smp;
      if (smp != prev_q)      cnt_d = CW'(1);
      else if (cnt_q != CMAX) cnt_d = cnt_q + CW'(1);
    end
    hit_o = strobe_i & smp & (cnt_d == CMAX);
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      sync_q <= 2'b00;
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/tamp_prio.sv
module tamp_prio #(
  parameter int N  = 15,
  parameter int RW = 4
) (
  input  logic [N-1:0]  flags_i,
  output logic [RW-1:0] code_o
);
  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (flags_i[i]) code_o = RW'(i + 1);
    end
  end
endmodule

// File: rtl/tamper_ctrl.sv
module tamper_ctrl #(
  parameter int DW         = 16,
  parameter int N_EXT      = 2,
  parameter int N_INT      = 13,
  parameter logic [N_INT-1:0] UNUSED_INT = 13'h0208,
  parameter int SAMPLE_DIV = 256,
  parameter int PRE_CYC    = 8,
  parameter int FILT_N     = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_vld,
  input  logic                               req_wr,
  input  logic [2:0]                         req_addr,
  input  logic [DW-1:0]                      req_wdata,
  output logic [DW-1:0]                      rd_data,
  input  logic [N_EXT-1:0]                   ext_tamper_n,
  input  logic [N_INT-1:0]                   int_tamper,
  output logic                               pch_o,
  output logic                               erase_o,
  output logic                               irq_o,
  output logic [$clog2(N_EXT+N_INT+1)-1:0]   reason_o
);
  import tamp_pkg::*;

  localparam int NSRC = N_EXT + N_INT;
  localparam int RW   = $clog2(NSRC + 1);
  localparam logic [NSRC-1:0] VALID = {~UNUSED_INT, {N_EXT{1'b1}}};

  logic rst_meta_q, rst_l;
  logic strobe, pch_win;
  logic [N_EXT-1:0] ext_hit;
  logic [NSRC-1:0] ena_q, ena_d, ien_q, ien_d, flags_q, flags_d;
  logic [NSRC-1:0] set_vec, clr_vec;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic erase_q, erase_d;
  logic wr_go;
  logic [RW-1:0] reason;
  logic wdata_unused;

  assign wdata_unused = ^req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_l      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_l      <= rst_meta_q;
    end
  end

  tamp_tick #(.DIV(SAMPLE_DIV), .PRE(PRE_CYC)) u_tick (
    .clk(clk), .rst_l(rst_l), .strobe_o(strobe), .pch_win_o(pch_win)
  );

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    tamp_filter #(.FILT_N(FILT_N)) u_filt (
      .clk(clk), .rst_l(rst_l), .strobe_i(strobe),
      .pin_n_i(ext_tamper_n[g]), .hit_o(ext_hit[g])
    );
  end

  tamp_prio #(.N(NSRC), .RW(RW)) u_prio (.flags_i(flags_q), .code_o(reason));

  always_comb begin
    wr_go   = req_vld & req_wr;
    ena_d   = (wr_go && req_addr == A_ENA) ? (req_wdata[NSRC-1:0] & VALID) : ena_q;
    ien_d   = (wr_go && req_addr == A_IEN) ? (req_wdata[NSRC-1:0] & VALID) : ien_q;
    cfg_d   = (wr_go && req_addr == A_CFG) ? req_wdata[CFG_W-1:0] : cfg_q;
    clr_vec = (wr_go && req_addr == A_CLR) ? req_wdata[NSRC-1:0] : '0;
    set_vec = {int_tamper, ext_hit} & ena_q;
    flags_d = (flags_q | set_vec) & ~clr_vec;
    erase_d = ~cfg_q[CFG_NOERASE] & (|(flags_d & ~flags_q));
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      ena_q   <= '0;
      ien_q   <= '0;
      cfg_q   <= '0;
      flags_q <= '0;
      erase_q <= 1'b0;
    end else begin
      ena_q   <= ena_d;
      ien_q   <= ien_d;
      cfg_q   <= cfg_d;
      flags_q <= flags_d;
      erase_q <= erase_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (req_vld && !req_wr) begin
      case (req_addr)
        A_ENA:   rd_data[NSRC-1:0]  = ena_q;
        A_IEN:   rd_data[NSRC-1:0]  = ien_q;
        A_STAT:  rd_data[NSRC-1:0]  = flags_q;
        A_CFG:   rd_data[CFG_W-1:0] = cfg_q;
        A_RSN:   rd_data[RW-1:0]    = reason;
        default: rd_data = '0;
      endcase
    end
  end

  assign pch_o    = pch_win & ~cfg_q[CFG_PCH_OFF];
  assign erase_o  = erase_q;
  assign irq_o    = |(flags_q & ien_q);
  assign reason_o = reason;
endmodule

// File: rtl/tamper_ctrl_chk.sv
module tamper_ctrl_chk #(
  parameter int DW = 16,
  parameter int NSRC = 15,
  parameter int RW = 4,
  parameter logic [NSRC-1:0] VALID = '1
) (
  input logic            clk,
  input logic            rst_l,
  input logic            req_vld,
  input logic            req_wr,
  input logic [2:0]      req_addr,
  input logic [DW-1:0]   req_wdata,
  input logic [NSRC-1:0] flags_q,
  input logic [1:0]      cfg_q,
  input logic            pch_o,
  input logic            erase_o,
  input logic            irq_o,
  input logic [RW-1:0]   reason_o
);
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_l)
    (flags_q & ~VALID) == '0); // R2

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_l)
    (req_vld && req_wr && req_addr == 3'd3) |=>
      ((flags_q & $past(req_wdata[NSRC-1:0])) == '0)); // R4

  AST_PCH_MUTED: assert property (@(posedge clk) disable iff (!rst_l)
    cfg_q[0] |-> !pch_o); // R5

  AST_ERASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_l)
    erase_o |-> ((flags_q != '0) && !$past(cfg_q[1]))); // R8

  AST_IRQ_REASON: assert property (@(posedge clk) disable iff (!rst_l)
    irq_o |-> (reason_o != '0)); // R9

  AST_REASON_FLAG: assert property (@(posedge clk) disable iff (!rst_l)
    (reason_o != '0) |-> flags_q[reason_o - RW'(1)]); // R10
endmodule

bind tamper_ctrl tamper_ctrl_chk #(
  .DW(DW), .NSRC(N_EXT + N_INT), .RW($clog2(N_EXT + N_INT + 1)),
  .VALID({~UNUSED_INT, {N_EXT{1'b1}}})
) u_chk (
  .clk(clk), .rst_l(rst_l), .req_vld(req_vld), .req_wr(req_wr),
  .req_addr(req_addr), .req_wdata(req_wdata), .flags_q(flags_q),
  .cfg_q(cfg_q), .pch_o(pch_o), .erase_o(erase_o), .irq_o(irq_o),
  .reason_o(reason_o)
);

// File: tb/sim_tamper_ctrl.sv
module sim_tamper_ctrl;
  localparam int D = 16, PRE = 4, FN = 3;
  localparam logic [14:0] VALIDB = 15'h7FFF & ~(15'h0208 << 2);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_vld = 1'b0, req_wr = 1'b0;
  logic [2:0] req_addr = '0;
  logic [15:0] req_wdata = '0, rd_data;
  logic [1:0] ext_n = 2'b11;
  logic [12:0] itp = '0;
  logic pch_o, erase_o, irq_o;
  logic [3:0] reason_o;
  int n_chk = 0, n_err = 0;
  logic [15:0] r;

  always #10 clk = ~clk;

  tamper_ctrl #(.SAMPLE_DIV(D), .PRE_CYC(PRE), .FILT_N(FN)) u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .ext_tamper_n(ext_n), .int_tamper(itp), .pch_o(pch_o),
    .erase_o(erase_o), .irq_o(irq_o), .reason_o(reason_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    req_vld = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_vld = 1'b0; req_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    req_vld = 1'b1; req_wr = 1'b0; req_addr = a;
    #1 d = rd_data;
    req_vld = 1'b0;
  endtask

  task automatic pulse(input logic [12:0] v);
    @(negedge clk); itp = v;
    @(negedge clk); itp = '0;
  endtask

  // returns at the falling edge just after a sample edge
  task automatic after_sample();
    while (pch_o !== 1'b1) @(negedge clk);
    while (pch_o !== 1'b0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), r); chk("R1 reg", 32'(r), 0);
    end
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 erase", 32'(erase_o), 0);
    chk("R1 reason", 32'(reason_o), 0);

    // R2 reserved positions
    wr(3'd0, 16'hFFFF); rd(3'd0, r); chk("R2 ena mask", 32'(r), 32'(VALIDB));
    wr(3'd1, 16'hFFFF); rd(3'd1, r); chk("R2 ien mask", 32'(r), 32'(VALIDB));
    wr(3'd1, 16'h0000);
    pulse(13'h1FFF);
    rd(3'd2, r); chk("R2 status all", 32'(r), 32'(VALIDB & 15'h7FFC));
    wr(3'd3, 16'h7FFF); rd(3'd2, r); chk("R4 clear all", 32'(r), 0);

    // R3 disabled source has no effect
    wr(3'd0, 16'h0000);
    pulse(13'h1FFF);
    rd(3'd2, r); chk("R3 disabled", 32'(r), 0);
    chk("R8 no erase when nothing latches", 32'(erase_o), 0);
    wr(3'd0, 16'(VALIDB));

    // R3/R8/R10 each internal source alone
    for (int j = 0; j < 13; j++) begin
      if (j == 3 || j == 9) continue;
      pulse(13'(1 << j));
      rd(3'd2, r); chk("R3 latch", 32'(r), 32'(1 << (j + 2)));
      chk("R8 erase pulse", 32'(erase_o), 1);
      chk("R10 single reason", 32'(reason_o), 32'(j + 3));
      @(negedge clk);
      chk("R8 erase one cycle", 32'(erase_o), 0);
      wr(3'd3, 16'h7FFF);
    end

    // R10 pair sweep
    for (int i = 0; i < 13; i++) begin
      for (int j = i + 1; j < 13; j++) begin
        if (i == 3 || i == 9 || j == 3 || j == 9) continue;
        pulse(13'((1 << i) | (1 << j)));
        chk("R10 pair priority", 32'(reason_o), 32'(i + 3));
        wr(3'd3, 16'h7FFF);
      end
    end
    rd(3'd5, r); chk("R10 unknown", 32'(r), 0);

    // R4 clear while active re-latches
    @(negedge clk); itp = 13'h0001;
    @(negedge clk);
    wr(3'd3, 16'h0004);
    rd(3'd2, r); chk("R4 clear wins", 32'(r), 0);
    @(negedge clk);
    rd(3'd2, r); chk("R4 relatch", 32'(r), 32'h4);
    chk("R8 erase on relatch", 32'(erase_o), 1);
    itp = '0;
    wr(3'd3, 16'h7FFF);

    // R9 interrupt
    pulse(13'h0004);
    chk("R9 irq off without ien", 32'(irq_o), 0);
    wr(3'd1, 16'h0010);
    chk("R9 irq on", 32'(irq_o), 1);
    repeat (5) @(negedge clk);
    chk("R9 irq held", 32'(irq_o), 1);
    wr(3'd3, 16'h0010);
    chk("R9 irq cleared", 32'(irq_o), 0);
    wr(3'd1, 16'h0000);

    // R8 erase inhibited
    wr(3'd4, 16'h0002);
    pulse(13'h0002);
    rd(3'd2, r); chk("R8 flag still latches", 32'(r), 32'h8);
    chk("R8 erase inhibited", 32'(erase_o), 0);
    wr(3'd3, 16'h7FFF);
    wr(3'd4, 16'h0000);

    // R5/R6 precharge window and period
    while (pch_o !== 1'b1) @(negedge clk);
    begin
      int hi = 0, per = 0;
      while (pch_o === 1'b1) begin hi++; per++; @(negedge clk); end
      while (pch_o !== 1'b1) begin per++; @(negedge clk); end
      chk("R5 precharge length", 32'(hi), 32'(PRE));
      chk("R6 sample period", 32'(per), 32'(D));
    end
    wr(3'd4, 16'h0001);
    begin
      int seen = 0;
      for (int k = 0; k < 2 * D; k++) begin
        @(negedge clk); if (pch_o) seen++;
      end
      chk("R5 precharge disabled", 32'(seen), 0);
    end
    wr(3'd4, 16'h0000);
    rd(3'd2, r); chk("R7 inactive high pins", 32'(r), 0);

    // R7 filter count
    after_sample();
    ext_n[0] = 1'b0;
    for (int k = 1; k <= FN; k++) begin
      after_sample();
      rd(3'd2, r);
      chk("R7 ext1 count", 32'(r[0]), (k == FN) ? 1 : 0);
    end
    chk("R10 ext1 top priority", 32'(reason_o), 1);
    ext_n[0] = 1'b1;
    after_sample();
    wr(3'd3, 16'h7FFF);

    // R7 restart on disagreeing sample, pin 2
    ext_n[1] = 1'b0;
    for (int k = 1; k < FN; k++) after_sample();
    ext_n[1] = 1'b1;
    after_sample();
    ext_n[1] = 1'b0;
    for (int k = 1; k <= FN; k++) begin
      after_sample();
      rd(3'd2, r);
      chk("R7 ext2 restart", 32'(r[1]), (k == FN) ? 1 : 0);
    end
    chk("R10 ext2 reason", 32'(reason_o), 2);
    ext_n[1] = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule